// File: doc/BRIEF.md
# Multi-Master Doorbell Register Block

This block holds a parameterised number of doorbell units that masters use to signal one another. Each unit belongs to one owning master and keeps a 32-bit allow mask, a 32-bit record of rings (one bit per master ID), and a derived pending view, which is the record masked by the allow mask. A master rings a unit by writing to its ring register. The write carries the master's ID, and that ID picks which record bit is set. A ring from a master that the target has not allowed leaves no trace. Each unit drives a level interrupt toward its owner while any pending bit is set.

The owner reads the pending word and writes the same value back to it. Each one written clears that pending bit together with the matching record bit. The owner can remove a master from the allow mask at any time. That hides the master's recorded ring without discarding it, and the ring shows again once the master is allowed back.

Register access uses a valid/ready request channel and a valid/ready read-response channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read yields exactly one response, and that response is held until it is taken. While a response is waiting and `rsp_ready` is low, the block takes no new request. Writes produce no response.

Top module: `doorbell_bank`

## Requirements
- R1: After reset every unit's allow mask and ring record are zero, every `irq` bit is low, `rsp_valid` is low and `req_ready` is high.
- R2: An accepted write to a unit's ring register (byte offset 0x0) with `req_wdata[0]=1` sets record bit `req_id` if allow-mask bit `req_id` is set. With `req_wdata[0]=0` the write does nothing.
- R3: A ring from a master whose allow-mask bit is clear leaves the ring record and the interrupt unchanged.
- R4: Reading offset 0xC returns the pending word, which is the ring record ANDed with the allow mask. Reading offset 0x8 returns the ring record.
- R5: `irq[d]` is high exactly while unit d has at least one pending bit.
- R6: A write to offset 0xC clears, for every bit set in `req_wdata`, that pending bit and the matching record bit. Bits written as zero are kept.
- R7: Unit d occupies byte addresses d*0x100 to d*0x100+0xF. Offset 0x4 is the allow mask, written and read as a whole word. Offset 0x0 reads as zero. A write to offset 0x8 is ignored.
- R8: Addresses with a unit index of `NUM_DB` or more, a nonzero offset bits [7:4], or nonzero bits [1:0] are ignored on write and read as zero.
- R9: A read accepted at a clock edge presents `rsp_valid` with its data after that edge. With `rsp_ready` low the response data stays stable and `req_ready` stays low.
- R10: Clearing an allow-mask bit hides a recorded ring from pending and from `irq` but keeps it in the record. Setting the bit again shows the ring once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_id | input | ID_W | ID of the issuing master |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | DATA_W | Read data |
| irq | output | NUM_DB | Level interrupt per unit |

## Verification
The bench targets gating. A ring from a disallowed master, or a ring write with data bit 0 low, must not set a record bit. A design that ignored the mask would raise `irq` at the wrong time. It also targets partial write-one-to-clear. A design that cleared the whole word, or only the pending view and not the record, would drop a neighbouring ring or bring it back. Hiding and then re-allowing a recorded ring catches a design that clears the record when the mask changes. Out-of-range and misaligned addresses catch decoders that alias into a real unit. A stalled response checks that data does not move and that no second request slips in.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  typedef enum logic [1:0] {
    REG_RING  = 2'd0,
    REG_ALLOW = 2'd1,
    REG_REC   = 2'd2,
    REG_PEND  = 2'd3
  } db_reg_e;
endpackage

// File: rtl/db_decode.sv
module db_decode #(
  parameter int ADDR_W   = 12,
  parameter int NUM_DB   = 4,
  parameter int WIN_LG   = 8,
  parameter int IDX_W    = 2
) (
  input  logic [ADDR_W-1:0]        addr_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o,
  output doorbell_pkg::db_reg_e    reg_o
);
  localparam int FULL_W = ADDR_W - WIN_LG;
  localparam logic [FULL_W-1:0] NUM_DB_V = FULL_W'(NUM_DB);

  logic [FULL_W-1:0] idx_full;

  always_comb begin
    idx_full = addr_i[ADDR_W-1:WIN_LG];
    idx_o    = idx_full[IDX_W-1:0];
    reg_o    = doorbell_pkg::db_reg_e'(addr_i[3:2]);
    hit_o    = (idx_full < NUM_DB_V) &&
               (addr_i[WIN_LG-1:4] == '0) &&
               (addr_i[1:0] == 2'b00);
  end
endmodule

// File: rtl/db_unit.sv
module db_unit #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ring_i,
  input  logic [ID_W-1:0]   ring_id_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] allow_o,
  output logic [DATA_W-1:0] rec_o,
  output logic [DATA_W-1:0] pend_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] allow_q, rec_q;
  logic [DATA_W-1:0] ring_vec, set_vec, clr_vec;

  always_comb begin
    ring_vec = '0;
    ring_vec[ring_id_i] = ring_i;
    set_vec  = ring_vec & allow_q;
    clr_vec  = clr_i ? (wdata_i & allow_q) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      allow_q <= '0;
      rec_q   <= '0;
    end else begin
      if (allow_wr_i) allow_q <= wdata_i;
      rec_q <= (rec_q & ~clr_vec) | set_vec;
    end
  end

  assign allow_o = allow_q;
  assign rec_o   = rec_q;
  assign pend_o  = rec_q & allow_q;
  assign irq_o   = |pend_o;

  // R2: an allowed ring is recorded on the next cycle
  a_r2_ring_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_i && allow_q[ring_id_i]) |=> rec_q[$past(ring_id_i)]);

  // R3: a disallowed ring leaves its record bit alone
  a_r3_ring_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_i && !allow_q[ring_id_i] && !clr_i) |=>
      (rec_q[$past(ring_id_i)] == $past(rec_q[ring_id_i])));

  // R6: cleared bits are gone from the record afterwards
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((rec_q & $past(wdata_i & allow_q)) == '0));
endmodule

// File: rtl/db_rsp.sv
module db_rsp #(
  parameter int DATA_W = 32,
  parameter int NUM_DB = 4,
  parameter int IDX_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_fire_i,
  input  logic                           hit_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  doorbell_pkg::db_reg_e          reg_i,
  input  logic [NUM_DB-1:0][DATA_W-1:0]  allow_i,
  input  logic [NUM_DB-1:0][DATA_W-1:0]  rec_i,
  input  logic [NUM_DB-1:0][DATA_W-1:0]  pend_i,
  input  logic                           rsp_ready_i,
  output logic                           rsp_valid_o,
  output logic [DATA_W-1:0]              rsp_rdata_o,
  output logic                           req_ready_o
);
  import doorbell_pkg::*;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (hit_i) begin
      unique case (reg_i)
        REG_ALLOW: rd_mux = allow_i[idx_i];
        REG_REC:   rd_mux = rec_i[idx_i];
        REG_PEND:  rd_mux = pend_i[idx_i];
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else if (rd_fire_i) begin
      rsp_valid_o <= 1'b1;
      rsp_rdata_o <= rd_mux;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;

  // R9: a stalled response holds its data
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)));

  // R9: a read is answered on the next cycle
  a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire_i |=> rsp_valid_o);
endmodule

// File: rtl/doorbell_bank.sv
module doorbell_bank #(
  parameter int NUM_DB = 4,
  parameter int ID_W   = 5,
  parameter int ADDR_W = 12,
  parameter int WIN_LG = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [ID_W-1:0]     req_id,
  input  logic [(1<<ID_W)-1:0] req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [(1<<ID_W)-1:0] rsp_rdata,
  output logic [NUM_DB-1:0]   irq
);
  import doorbell_pkg::*;

  localparam int DATA_W = 1 << ID_W;
  localparam int IDX_W  = (NUM_DB > 1) ? $clog2(NUM_DB) : 1;

  logic              fire, wr_fire, rd_fire, hit;
  logic [IDX_W-1:0]  idx;
  db_reg_e           reg_sel;
  logic [NUM_DB-1:0][DATA_W-1:0] allow_w, rec_w, pend_w;

  assign fire    = req_valid && req_ready;
  assign wr_fire = fire && req_we;
  assign rd_fire = fire && !req_we;

  db_decode #(.ADDR_W(ADDR_W), .NUM_DB(NUM_DB), .WIN_LG(WIN_LG), .IDX_W(IDX_W)) u_dec (
    .addr_i (req_addr),
    .hit_o  (hit),
    .idx_o  (idx),
    .reg_o  (reg_sel)
  );

  for (genvar d = 0; d < NUM_DB; d++) begin : g_unit
    logic sel;
    assign sel = wr_fire && hit && (idx == IDX_W'(d));
    db_unit #(.DATA_W(DATA_W), .ID_W(ID_W)) u_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .allow_wr_i (sel && (reg_sel == REG_ALLOW)),
      .wdata_i    (req_wdata),
      .ring_i     (sel && (reg_sel == REG_RING) && req_wdata[0]),
      .ring_id_i  (req_id),
      .clr_i      (sel && (reg_sel == REG_PEND)),
      .allow_o    (allow_w[d]),
      .rec_o      (rec_w[d]),
      .pend_o     (pend_w[d]),
      .irq_o      (irq[d])
    );
  end

  db_rsp #(.DATA_W(DATA_W), .NUM_DB(NUM_DB), .IDX_W(IDX_W)) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire_i   (rd_fire),
    .hit_i       (hit),
    .idx_i       (idx),
    .reg_i       (reg_sel),
    .allow_i     (allow_w),
    .rec_i       (rec_w),
    .pend_i      (pend_w),
    .rsp_ready_i (rsp_ready),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata),
    .req_ready_o (req_ready)
  );

  // R9: no request is taken while a stalled response waits
  a_r9_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R8: a missed address never changes an interrupt
  a_r8_miss_no_irq_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !hit) |=> $stable(irq));
endmodule

// File: tb/sim_doorbell_bank.sv
module sim_doorbell_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [4:0]  id;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  irq;
    logic [3:0]  rq;
  } vec_t;

  // Columns: we, addr, id, wdata, expected read, expected irq, requirement
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h008, 5'd0,  32'h0,        32'h0,        4'b0000, 4'd1},  // R1
    '{1'b0, 12'h30C, 5'd0,  32'h0,        32'h0,        4'b0000, 4'd1},  // R1
    '{1'b1, 12'h104, 5'd0,  32'h9,        32'h0,        4'b0000, 4'd7},  // allow 0,3
    '{1'b0, 12'h104, 5'd0,  32'h0,        32'h9,        4'b0000, 4'd7},  // R7
    '{1'b1, 12'h100, 5'd3,  32'h1,        32'h0,        4'b0010, 4'd2},  // R2
    '{1'b0, 12'h108, 5'd0,  32'h0,        32'h8,        4'b0010, 4'd2},  // R2
    '{1'b1, 12'h100, 5'd5,  32'h1,        32'h0,        4'b0010, 4'd3},  // R3
    '{1'b0, 12'h108, 5'd0,  32'h0,        32'h8,        4'b0010, 4'd3},  // R3
    '{1'b1, 12'h100, 5'd0,  32'h0,        32'h0,        4'b0010, 4'd2},  // R2 bit0 low
    '{1'b0, 12'h10C, 5'd0,  32'h0,        32'h8,        4'b0010, 4'd2},  // R2
    '{1'b1, 12'h100, 5'd0,  32'h1,        32'h0,        4'b0010, 4'd2},
    '{1'b0, 12'h10C, 5'd0,  32'h0,        32'h9,        4'b0010, 4'd4},  // R4
    '{1'b1, 12'h10C, 5'd0,  32'h8,        32'h0,        4'b0010, 4'd6},  // R6 partial
    '{1'b0, 12'h108, 5'd0,  32'h0,        32'h1,        4'b0010, 4'd6},  // R6
    '{1'b1, 12'h104, 5'd0,  32'h8,        32'h0,        4'b0000, 4'd10}, // R10 hide
    '{1'b0, 12'h10C, 5'd0,  32'h0,        32'h0,        4'b0000, 4'd10}, // R10
    '{1'b0, 12'h108, 5'd0,  32'h0,        32'h1,        4'b0000, 4'd10}, // R10 kept
    '{1'b1, 12'h104, 5'd0,  32'h9,        32'h0,        4'b0010, 4'd10}, // R10 show
    '{1'b0, 12'h10C, 5'd0,  32'h0,        32'h1,        4'b0010, 4'd4},  // R4
    '{1'b1, 12'h108, 5'd0,  32'hFFFFFFFF, 32'h0,        4'b0010, 4'd7},  // R7 ro
    '{1'b0, 12'h108, 5'd0,  32'h0,        32'h1,        4'b0010, 4'd7},  // R7
    '{1'b0, 12'h100, 5'd0,  32'h0,        32'h0,        4'b0010, 4'd7},  // R7 ring reads 0
    '{1'b1, 12'h304, 5'd0,  32'h80000000, 32'h0,        4'b0010, 4'd7},
    '{1'b1, 12'h300, 5'd31, 32'h1,        32'h0,        4'b1010, 4'd5},  // R5
    '{1'b0, 12'h30C, 5'd0,  32'h0,        32'h80000000, 4'b1010, 4'd4},
    '{1'b1, 12'h504, 5'd0,  32'hFF,       32'h0,        4'b1010, 4'd8},  // R8
    '{1'b1, 12'h314, 5'd0,  32'h0,        32'h0,        4'b1010, 4'd8},  // R8 reserved
    '{1'b0, 12'h505, 5'd0,  32'h0,        32'h0,        4'b1010, 4'd8},  // R8
    '{1'b1, 12'h10C, 5'd0,  32'h1,        32'h0,        4'b1000, 4'd5},  // R5
    '{1'b1, 12'h30C, 5'd0,  32'h80000000, 32'h0,        4'b0000, 4'd5}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [4:0]  req_id = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  irq;
  int total = 0, bad = 0;
  logic [31:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_id(req_id), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic we, input logic [11:0] a, input logic [4:0] id,
                       input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_id = id; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 irq", {28'h0, irq}, 32'h0);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", {31'h0, req_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].we, VEC[i].addr, VEC[i].id, VEC[i].wdata);
      if (!VEC[i].we) begin
        check($sformatf("R%0d rsp_valid vec%0d", VEC[i].rq, i), {31'h0, rsp_valid}, 32'h1);
        check($sformatf("R%0d rdata vec%0d", VEC[i].rq, i), rsp_rdata, VEC[i].exp);
      end
      check($sformatf("R%0d irq vec%0d", VEC[i].rq, i), {28'h0, irq}, {28'h0, VEC[i].irq});
    end

    // R9: stalled response, setup: allow master 2 on unit 2 and ring it
    issue(1'b1, 12'h204, 5'd0, 32'h4);
    issue(1'b1, 12'h200, 5'd2, 32'h1);
    rsp_ready = 1'b0;
    issue(1'b0, 12'h20C, 5'd0, 32'h0);
    check("R9 valid", {31'h0, rsp_valid}, 32'h1);
    check("R9 data", rsp_rdata, 32'h4);
    held = rsp_rdata;
    // attempt a clear of unit 2 while stalled; it must not be taken
    req_valid = 1'b1; req_we = 1'b1; req_addr = 12'h20C; req_wdata = 32'h4;
    repeat (3) begin
      @(negedge clk);
      check("R9 ready low", {31'h0, req_ready}, 32'h0);
      check("R9 held", rsp_rdata, held);
    end
    req_valid = 1'b0;
    check("R9 clear not taken", {28'h0, irq}, 32'h4);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 released", {31'h0, rsp_valid}, 32'h0);
    issue(1'b1, 12'h20C, 5'd0, 32'h4);
    check("R6 unit2 cleared", {28'h0, irq}, 32'h0);

    // R1: reset again clears all state
    issue(1'b1, 12'h004, 5'd0, 32'h1);
    issue(1'b1, 12'h000, 5'd0, 32'h1);
    check("R5 unit0 irq", {28'h0, irq}, 32'h1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 irq after reset", {28'h0, irq}, 32'h0);
    issue(1'b0, 12'h004, 5'd0, 32'h0);
    check("R1 allow after reset", rsp_rdata, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule